// File: doc/BRIEF.md
# Data Tenure Ordering Controller

This block decides when a bus master may begin the data phase of each address transaction it has already issued. There is no separate data-bus request line. Every transfer start that is not address-only adds an entry to a small queue of pending data tenures. Each entry is tagged as a read or a write and as a burst or a single transfer.

The block combines the external grant with its own busy state, the data-retry input and the address-retry input to form a qualified grant. On a qualified grant it picks one pending entry, drives data-busy for the length of that tenure, and pulses start and finish strobes.

The write-only input is examined only on the edge where a qualified grant is taken. If it is high on that edge, the oldest pending write may run ahead of older pipelined reads. If it is low, tenures run in the order their address phases were issued.

The controller is built around a two-state machine:
- `DT_IDLE` waits for a qualified grant.
- `DT_XFER` counts data beats.

There are three transitions:
- **idle→xfer** on a qualified grant.
- **xfer→idle (finish)** after the last beat.
- **xfer→idle (retry)** when data retry is seen during a tenure.

Top module: `dten_order_ctrl`

## Requirements
- R1: A tenure begins only when, on a clock edge, the grant input is high, data-busy is low, data retry is low, address retry is low, and at least one entry is pending. In the cycle after that edge, data-busy and the start strobe are both high.
- R2: A burst entry (burst flag 1) keeps data-busy high for exactly 4 cycles. A single entry (burst flag 0) keeps it high for exactly 1 cycle. The finish strobe is high only in the last busy cycle, and the entry then leaves the queue.
- R3: With the write-only input low at the grant edge, the entry at queue position 0 (the oldest) is serviced.
- R4: With the write-only input high at the grant edge, the oldest pending write is serviced, even when an older read is pending. The write tag (1 = write) is shown on the tenure-write output throughout the tenure.
- R5: With the write-only input high at the grant edge and no write pending, the oldest read is serviced.
- R6: The write-only input has no effect on any edge other than the qualified-grant edge.
- R7: Grant has no effect while the queue is empty. An address-only transfer start adds no entry.
- R8: The stall output is high while 2 entries are pending. A non-address-only start made while stalled is refused and adds no entry.
- R9: Data retry during a tenure ends that tenure in the same cycle with no finish strobe. Data-busy is low in the next cycle. The entry keeps its queue position, and a later qualified grant runs it again.
- R10: Address retry with a position index removes the pending entry at that position (0 = oldest) without running it. The retry is ignored when the index points at the entry whose tenure is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start_i | input | 1 | Address transfer start |
| xfer_write_i | input | 1 | Transfer is a write (1) or read (0) |
| xfer_burst_i | input | 1 | Transfer is a 4-beat burst (1) or single (0) |
| xfer_addr_only_i | input | 1 | Transfer has no data phase |
| xfer_stall_o | output | 1 | Queue full; transfer start refused |
| grant_i | input | 1 | Data bus grant from the arbiter |
| write_only_i | input | 1 | Let the oldest write bypass older reads |
| dretry_i | input | 1 | Data retry |
| aretry_i | input | 1 | Address retry for the entry at aretry_idx_i |
| aretry_idx_i | input | IDX_W | Queue position addressed by the address retry |
| dbusy_o | output | 1 | Data bus busy |
| ten_start_o | output | 1 | First cycle of a tenure |
| ten_write_o | output | 1 | Current tenure is a write |
| ten_done_o | output | 1 | Last cycle of a tenure that completes |

## Verification
Data-busy, the start strobe and the tenure-write output all come from registers. They change one cycle after the edge that takes the qualified grant. The finish strobe is combinational from the beat count and data retry, so it is due within the last busy cycle itself. The stall output follows the pending count with no delay.

The bench drives inputs 1 ns after a rising edge and samples outputs at that same point after the next edge. Each check therefore sees exactly one registered step. Tenure lengths are measured by counting the cycles of data-busy from the grant edge.

// File: rtl/dten_pkg.sv
package dten_pkg;

    typedef struct packed {
        logic wr;
        logic burst;
    } dten_entry_t;

    typedef enum logic {
        DT_IDLE = 1'b0,
        DT_XFER = 1'b1
    } dten_state_t;

endpackage

// File: rtl/dten_queue.sv
module dten_queue
    import dten_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  dten_entry_t       push_ent,
    input  logic [DEPTH-1:0]  rm_mask,
    output dten_entry_t       ents [DEPTH],
    output logic [DEPTH-1:0]  vld,
    output logic [CNT_W-1:0]  count
);

    dten_entry_t      ent_q   [DEPTH];
    dten_entry_t      ent_nxt [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] vld_nxt;

    // Compaction: survivors slide toward position 0, then any push lands behind them.
    always_comb begin
        logic [CNT_W-1:0] k;
        k = '0;
        vld_nxt = '0;
        for (int i = 0; i < DEPTH; i++) ent_nxt[i] = ent_q[i];
        for (int i = 0; i < DEPTH; i++) begin
            if (vld_q[i] && !rm_mask[i]) begin
                ent_nxt[k] = ent_q[i];
                vld_nxt[k] = 1'b1;
                k = k + 1'b1;
            end
        end
        if (push && (k < CNT_W'(DEPTH))) begin
            ent_nxt[k] = push_ent;
            vld_nxt[k] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            vld_q <= vld_nxt;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_nxt[i];
        end
    end

    assign vld   = vld_q;
    assign count = CNT_W'($countones(vld_q));

    always_comb begin
        for (int i = 0; i < DEPTH; i++) ents[i] = ent_q[i];
    end

    // R10/R2: the queue stays packed from position 0 after any removal.
    assert_queue_packed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q == DEPTH'((1 << count) - 1));

endmodule

// File: rtl/dten_select.sv
module dten_select
    import dten_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  dten_entry_t       ents [DEPTH],
    input  logic [DEPTH-1:0]  vld,
    input  logic              write_only,
    output logic [IDX_W-1:0]  sel_idx,
    output logic              sel_wr,
    output logic              sel_burst
);

    logic [IDX_W-1:0] wr_idx;
    logic             wr_found;

    // Oldest pending write: lowest valid position tagged as a write.
    always_comb begin
        wr_idx   = '0;
        wr_found = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!wr_found && vld[i] && ents[i].wr) begin
                wr_found = 1'b1;
                wr_idx   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        sel_idx   = (write_only && wr_found) ? wr_idx : '0;
        sel_wr    = ents[sel_idx].wr;
        sel_burst = ents[sel_idx].burst;
    end

endmodule

// File: rtl/dten_fsm.sv
module dten_fsm
    import dten_pkg::*;
#(
    parameter int DEPTH       = 2,
    parameter int BURST_BEATS = 4,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int BEAT_W = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              qual,
    input  logic [IDX_W-1:0]  sel_idx,
    input  logic              sel_wr,
    input  logic              sel_burst,
    input  logic              dretry,
    input  logic              shift_down,
    output logic [IDX_W-1:0]  act_idx,
    output logic              dbusy,
    output logic              ten_start,
    output logic              ten_write,
    output logic              ten_done
);

    localparam logic [BEAT_W-1:0] LAST_BURST = BEAT_W'(BURST_BEATS - 1);

    dten_state_t       state_q;
    logic [BEAT_W-1:0] beat_q;
    logic [IDX_W-1:0]  idx_q;
    logic              burst_q;
    logic              wr_q;
    logic              last_beat;

    assign last_beat = burst_q ? (beat_q == LAST_BURST) : 1'b1;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DT_IDLE;
            beat_q  <= '0;
            idx_q   <= '0;
            burst_q <= 1'b0;
            wr_q    <= 1'b0;
        end else begin
            unique case (state_q)
                DT_IDLE: begin
                    if (qual) begin
                        state_q <= DT_XFER;
                        beat_q  <= '0;
                        idx_q   <= sel_idx;
                        burst_q <= sel_burst;
                        wr_q    <= sel_wr;
                    end
                end
                DT_XFER: begin
                    if (dretry || last_beat) begin
                        state_q <= DT_IDLE;
                    end else begin
                        beat_q <= beat_q + 1'b1;
                    end
                    if (shift_down) idx_q <= idx_q - 1'b1;
                end
                default: state_q <= DT_IDLE;
            endcase
        end
    end

    // Output process
    always_comb begin
        dbusy     = 1'b0;
        ten_start = 1'b0;
        ten_done  = 1'b0;
        unique case (state_q)
            DT_IDLE: ;
            DT_XFER: begin
                dbusy     = 1'b1;
                ten_start = (beat_q == '0);
                ten_done  = last_beat && !dretry;
            end
            default: ;
        endcase
    end

    assign ten_write = dbusy && wr_q;
    assign act_idx   = idx_q;

    // R1: the start strobe only ever appears inside a tenure.
    assert_start_in_tenure_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ten_start |-> dbusy);

    // R2: a single-beat tenure holds busy for one cycle only.
    assert_single_one_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ten_start && !burst_q) |=> !dbusy);

    // R9: data retry in a tenure suppresses the finish strobe and frees the bus.
    assert_retry_no_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dbusy && dretry) |-> !ten_done);
    assert_retry_frees_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dbusy && dretry) |=> !dbusy);

endmodule

// File: rtl/dten_order_ctrl.sv
module dten_order_ctrl
    import dten_pkg::*;
#(
    parameter int DEPTH       = 2,
    parameter int BURST_BEATS = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_start_i,
    input  logic             xfer_write_i,
    input  logic             xfer_burst_i,
    input  logic             xfer_addr_only_i,
    output logic             xfer_stall_o,
    input  logic             grant_i,
    input  logic             write_only_i,
    input  logic             dretry_i,
    input  logic             aretry_i,
    input  logic [IDX_W-1:0] aretry_idx_i,
    output logic             dbusy_o,
    output logic             ten_start_o,
    output logic             ten_write_o,
    output logic             ten_done_o
);

    dten_entry_t      ents [DEPTH];
    dten_entry_t      push_ent;
    logic [DEPTH-1:0] vld;
    logic [CNT_W-1:0] count;
    logic [DEPTH-1:0] rm_mask;
    logic [IDX_W-1:0] sel_idx;
    logic [IDX_W-1:0] act_idx;
    logic             sel_wr;
    logic             sel_burst;
    logic             push;
    logic             qual;
    logic             aretry_ok;
    logic             shift_down;

    assign xfer_stall_o = (count == CNT_W'(DEPTH));
    assign push         = xfer_start_i && !xfer_addr_only_i && !xfer_stall_o;
    assign push_ent     = '{wr: xfer_write_i, burst: xfer_burst_i};

    // Qualified grant: bus free, no retries, something to service.
    assign qual = grant_i && !dbusy_o && !dretry_i && !aretry_i && (count != '0);

    assign aretry_ok  = aretry_i && (CNT_W'(aretry_idx_i) < count) &&
                        !(dbusy_o && (aretry_idx_i == act_idx));
    assign shift_down = aretry_ok && dbusy_o && (aretry_idx_i < act_idx);

    always_comb begin
        for (int j = 0; j < DEPTH; j++) begin
            rm_mask[j] = (ten_done_o && (act_idx == IDX_W'(j))) ||
                         (aretry_ok  && (aretry_idx_i == IDX_W'(j)));
        end
    end

    dten_queue #(.DEPTH(DEPTH)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_ent (push_ent),
        .rm_mask  (rm_mask),
        .ents     (ents),
        .vld      (vld),
        .count    (count)
    );

    dten_select #(.DEPTH(DEPTH)) u_select (
        .ents       (ents),
        .vld        (vld),
        .write_only (write_only_i),
        .sel_idx    (sel_idx),
        .sel_wr     (sel_wr),
        .sel_burst  (sel_burst)
    );

    dten_fsm #(.DEPTH(DEPTH), .BURST_BEATS(BURST_BEATS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .qual       (qual),
        .sel_idx    (sel_idx),
        .sel_wr     (sel_wr),
        .sel_burst  (sel_burst),
        .dretry     (dretry_i),
        .shift_down (shift_down),
        .act_idx    (act_idx),
        .dbusy      (dbusy_o),
        .ten_start  (ten_start_o),
        .ten_write  (ten_write_o),
        .ten_done   (ten_done_o)
    );

    // R1: busy only rises after an edge that saw grant with no data retry.
    assert_grant_before_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbusy_o) |-> ($past(grant_i) && !$past(dretry_i) && !$past(aretry_i)));

    // R8: a refused start with nothing leaving keeps the queue full.
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stall_o && !ten_done_o && !aretry_i) |=> xfer_stall_o);

    // R7: an empty queue never starts a tenure.
    assert_empty_no_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |=> !ten_start_o);

endmodule

// File: tb/sim_dten_order_ctrl.sv
`timescale 1ns/1ps
module sim_dten_order_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_start_i = 0, xfer_write_i = 0, xfer_burst_i = 0, xfer_addr_only_i = 0;
    logic grant_i = 0, write_only_i = 0, dretry_i = 0, aretry_i = 0;
    logic [0:0] aretry_idx_i = '0;
    logic xfer_stall_o, dbusy_o, ten_start_o, ten_write_o, ten_done_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dten_order_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .xfer_start_i(xfer_start_i), .xfer_write_i(xfer_write_i),
        .xfer_burst_i(xfer_burst_i), .xfer_addr_only_i(xfer_addr_only_i),
        .xfer_stall_o(xfer_stall_o), .grant_i(grant_i),
        .write_only_i(write_only_i), .dretry_i(dretry_i),
        .aretry_i(aretry_i), .aretry_idx_i(aretry_idx_i),
        .dbusy_o(dbusy_o), .ten_start_o(ten_start_o),
        .ten_write_o(ten_write_o), .ten_done_o(ten_done_o)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input bit wr, input bit burst, input bit aonly);
        xfer_start_i = 1; xfer_write_i = wr; xfer_burst_i = burst; xfer_addr_only_i = aonly;
        cyc();
        xfer_start_i = 0; xfer_write_i = 0; xfer_burst_i = 0; xfer_addr_only_i = 0;
    endtask

    // Grant for one edge, then measure the tenure that follows.
    task automatic run(input bit wo, output int len, output bit wr, output bit done_last);
        grant_i = 1; write_only_i = wo;
        cyc();
        grant_i = 0; write_only_i = 0;
        wr = ten_write_o; len = 0; done_last = 0;
        if (dbusy_o) chk("R1", "start strobe with busy", int'(ten_start_o), 1);
        while (dbusy_o && len < 20) begin
            done_last = ten_done_o;
            len++;
            cyc();
        end
    endtask

    task automatic expect_none(input string req);
        int len; bit wr; bit dn;
        run(1'b0, len, wr, dn);
        chk(req, "no tenure expected", len, 0);
        cyc();
        chk(req, "busy stays low", int'(dbusy_o), 0);
    endtask

    task automatic t_reset();
        chk("R1", "reset busy", int'(dbusy_o), 0);
        chk("R8", "reset stall", int'(xfer_stall_o), 0);
        chk("R2", "reset done", int'(ten_done_o), 0);
    endtask

    task automatic t_in_order();
        int len; bit wr; bit dn;
        push(0, 1, 0); push(1, 0, 0);
        run(0, len, wr, dn);
        chk("R3", "first is read", int'(wr), 0);
        chk("R2", "burst length", len, 4);
        chk("R2", "done in last beat", int'(dn), 1);
        run(0, len, wr, dn);
        chk("R3", "second is write", int'(wr), 1);
        chk("R2", "single length", len, 1);
        expect_none("R2");
    endtask

    task automatic t_write_bypass();
        int len; bit wr; bit dn;
        push(0, 1, 0); push(1, 0, 0);
        run(1, len, wr, dn);
        chk("R4", "write bypasses read", int'(wr), 1);
        chk("R4", "write length", len, 1);
        run(0, len, wr, dn);
        chk("R4", "read follows", int'(wr), 0);
        chk("R4", "read length", len, 4);
    endtask

    task automatic t_no_write();
        int len; bit wr; bit dn;
        push(0, 0, 0); push(0, 1, 0);
        run(1, len, wr, dn);
        chk("R5", "oldest read first (single)", len, 1);
        chk("R5", "is read", int'(wr), 0);
        run(1, len, wr, dn);
        chk("R5", "then burst read", len, 4);
    endtask

    task automatic t_wo_timing();
        int len; bit wr; bit dn;
        push(0, 0, 0); push(1, 1, 0);
        write_only_i = 1; cyc(); cyc(); write_only_i = 0;
        chk("R6", "no tenure from write-only alone", int'(dbusy_o), 0);
        run(0, len, wr, dn);
        chk("R6", "in order when low at grant", int'(wr), 0);
        run(1, len, wr, dn);
        chk("R6", "write second", int'(wr), 1);
        chk("R6", "write burst length", len, 4);
    endtask

    task automatic t_empty_and_aonly();
        expect_none("R7");
        push(1, 1, 1);
        expect_none("R7");
    endtask

    task automatic t_grant_low();
        push(1, 0, 0);
        cyc(); cyc();
        chk("R1", "no tenure without grant", int'(dbusy_o), 0);
        begin
            int len; bit wr; bit dn;
            run(0, len, wr, dn);
            chk("R1", "grant then runs", len, 1);
        end
    endtask

    task automatic t_stall();
        int len; bit wr; bit dn;
        push(0, 0, 0); push(1, 0, 0);
        chk("R8", "stall when full", int'(xfer_stall_o), 1);
        push(1, 1, 0);
        chk("R8", "still full", int'(xfer_stall_o), 1);
        run(0, len, wr, dn);
        chk("R8", "first entry read", int'(wr), 0);
        chk("R8", "stall clears", int'(xfer_stall_o), 0);
        run(0, len, wr, dn);
        chk("R8", "second entry single write", len, 1);
        expect_none("R8");
    endtask

    task automatic t_dretry();
        int len; bit wr; bit dn;
        push(1, 1, 0); push(0, 0, 0);
        grant_i = 1; dretry_i = 1; cyc(); grant_i = 0;
        chk("R9", "data retry blocks grant", int'(dbusy_o), 0);
        dretry_i = 0;
        grant_i = 1; cyc(); grant_i = 0;
        chk("R9", "tenure started", int'(dbusy_o), 1);
        cyc();
        dretry_i = 1; #1;
        chk("R9", "no done under retry", int'(ten_done_o), 0);
        cyc();
        dretry_i = 0;
        chk("R9", "busy drops after retry", int'(dbusy_o), 0);
        run(0, len, wr, dn);
        chk("R9", "same write re-granted", int'(wr), 1);
        chk("R9", "full burst on re-grant", len, 4);
        chk("R9", "done on re-grant", int'(dn), 1);
        run(0, len, wr, dn);
        chk("R9", "read kept behind", len, 1);
    endtask

    task automatic t_aretry();
        int len; bit wr; bit dn;
        push(0, 1, 0); push(1, 0, 0);
        aretry_i = 1; aretry_idx_i = 1'b0; grant_i = 1; cyc();
        aretry_i = 0; grant_i = 0;
        chk("R10", "no tenure with address retry", int'(dbusy_o), 0);
        run(0, len, wr, dn);
        chk("R10", "read removed, write runs", int'(wr), 1);
        chk("R10", "write single", len, 1);
        expect_none("R10");
        push(0, 1, 0);
        grant_i = 1; cyc(); grant_i = 0;
        aretry_i = 1; aretry_idx_i = 1'b0; cyc(); aretry_i = 0;
        len = 1;
        while (dbusy_o && len < 20) begin dn = ten_done_o; len++; cyc(); end
        chk("R10", "active entry not removed", len, 4);
        chk("R10", "active entry completes", int'(dn), 1);
        expect_none("R10");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        cyc();
        t_reset();
        t_in_order();
        t_write_bypass();
        t_no_write();
        t_wo_timing();
        t_empty_and_aonly();
        t_grant_low();
        t_stall();
        t_dretry();
        t_aretry();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule